// File: doc/BRIEF.md
# Triple-Coded Adder with Divisibility Check

This block adds two unsigned integers in a self-checking form. Each operand is multiplied by three on entry, which gives a coded word two bits wider than the data. The two coded words are added. Because the sum of two multiples of three is itself a multiple of three, a sum that leaves a remainder when divided by three must have been corrupted. The block computes that remainder with bit-pair weighting and raises a flag when it is not zero. Any single flipped bit changes the sum by a power of two, and a power of two is never a multiple of three, so every such flip is caught.

A fault-injection input can flip one chosen bit of the raw sum, including the carry bit, so that detection can be shown. A carry out of the coded width is reported on its own flag. A divide-by-three stage turns the coded sum back into a plain value. That value is driven only when neither flag is set and is forced to zero otherwise. All outputs are registered with one cycle of latency and carry a valid strobe.

Top module: `an_add_check`

## Requirements
- R1: While reset is asserted and after it is released, with no input accepted yet, out_valid, err_code, err_ovf, sum_code and sum_val are all zero.
- R2: For an accepted input, sum_code equals the low CW = DW+2 bits of 3·a_val + 3·b_val (after any injected flip). It appears on the clock edge that follows the one that sampled in_valid high.
- R3: out_valid is high for exactly the cycle after each edge that sampled in_valid high, and is low after an edge that sampled it low.
- R4: With fault_en low, err_code is never set, for every pair of operands including the largest ones.
- R5: With fault_en high and fault_pos in 0..CW, bit fault_pos of the (CW+1)-bit raw sum is inverted, and err_code is set for that result. Bit CW is the carry.
- R6: With fault_pos greater than CW, fault_en has no effect: the outputs equal those of the fault-free sum.
- R7: err_ovf equals bit CW of the (possibly flipped) raw sum. Without a fault it is set exactly when 3·(a_val+b_val) is at least 2^CW.
- R8: sum_val equals sum_code divided by three (that is a_val+b_val without a fault) when both flags are clear, and is zero when either flag is set.
- R9: After an edge that sampled in_valid low, sum_code, sum_val, err_code and err_ovf keep their previous values, whatever a_val, b_val, fault_en and fault_pos are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| a_val | input | DW | First plain operand |
| b_val | input | DW | Second plain operand |
| fault_en | input | 1 | Enable a one-bit flip of the raw sum |
| fault_pos | input | $clog2(CW+1) | Bit to flip, 0..CW (CW is the carry) |
| out_valid | output | 1 | Registered result valid |
| sum_code | output | CW | Coded sum, low CW bits |
| sum_val | output | DW+1 | Decoded sum, zero when flagged |
| err_code | output | 1 | Sum not divisible by three |
| err_ovf | output | 1 | Carry out of the coded width |

## Verification
The divisibility flag and the carry flag can both be raised by the same result. This happens when the operand sum already overflows the coded width and a flip is also injected, or when the injected flip lands on the carry bit itself. The bench provokes both cases and compares each flag separately against a behavioural model. It also checks that the decoded value is forced to zero. It further drives large operand pairs that overflow without any fault. There the carry flag must be set alone, which shows that the divisibility test covers the full raw sum and not only its truncated low bits.

// File: rtl/an_pkg.sv
package an_pkg;
    localparam int unsigned AN_FACTOR = 3;
    typedef logic [1:0] res3_t;
endpackage

// File: rtl/an_encode.sv
module an_encode #(
    parameter int DW = 16,
    localparam int CW = DW + 2
) (
    input  logic [DW-1:0] val,
    output logic [CW-1:0] code
);
    // 3*N = 2*N + N; two extra bits keep the product in range
    always_comb begin
        code = {1'b0, val, 1'b0} + {2'b00, val};
    end
endmodule

// File: rtl/an_mod3.sv
module an_mod3 #(
    parameter int W = 19
) (
    input  logic         [W-1:0] word,
    output an_pkg::res3_t        res
);
    localparam int SW = $clog2(2 * W + 1);
    logic [SW-1:0] acc;

    // 2^i mod 3 alternates 1,2: weight even bits by 1 and odd bits by 2
    always_comb begin
        acc = '0;
        for (int i = 0; i < W; i++) begin
            if (word[i]) begin
                acc = acc + ((i % 2 == 0) ? SW'(1) : SW'(2));
            end
        end
        res = an_pkg::res3_t'(acc % SW'(an_pkg::AN_FACTOR));
    end
endmodule

// File: rtl/an_decode.sv
module an_decode #(
    parameter int DW = 16,
    localparam int CW = DW + 2
) (
    input  logic [CW-1:0] code,
    output logic [DW:0]   val
);
    always_comb begin
        val = (DW+1)'(code / CW'(an_pkg::AN_FACTOR));
    end
endmodule

// File: rtl/an_add_check.sv
module an_add_check #(
    parameter int DW = 16,
    localparam int CW = DW + 2,
    localparam int PW = $clog2(CW + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [DW-1:0] a_val,
    input  logic [DW-1:0] b_val,
    input  logic          fault_en,
    input  logic [PW-1:0] fault_pos,
    output logic          out_valid,
    output logic [CW-1:0] sum_code,
    output logic [DW:0]   sum_val,
    output logic          err_code,
    output logic          err_ovf
);
    typedef struct packed {
        logic          vld;
        logic [CW-1:0] code;
        logic [DW:0]   val;
        logic          bad;
        logic          ovf;
    } stage_t;

    stage_t st_d, st_q;

    logic [CW-1:0]  enc_a, enc_b;
    logic [CW:0]    raw_sum;
    logic [CW:0]    flip_mask;
    logic [CW:0]    hit_sum;
    an_pkg::res3_t  rem3;
    logic [DW:0]    quot;

    an_encode #(.DW(DW)) u_enc_a (.val(a_val), .code(enc_a));
    an_encode #(.DW(DW)) u_enc_b (.val(b_val), .code(enc_b));

    // one flip-select line per bit of the raw sum, carry included
    for (genvar g = 0; g <= CW; g++) begin : g_flip
        assign flip_mask[g] = fault_en && (fault_pos == PW'(g));
    end

    always_comb begin
        raw_sum = {1'b0, enc_a} + {1'b0, enc_b};
        hit_sum = raw_sum ^ flip_mask;
    end

    an_mod3   #(.W(CW + 1)) u_mod3 (.word(hit_sum), .res(rem3));
    an_decode #(.DW(DW))    u_dec  (.code(hit_sum[CW-1:0]), .val(quot));

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) begin
            st_d.code = hit_sum[CW-1:0];
            st_d.bad  = (rem3 != '0);
            st_d.ovf  = hit_sum[CW];
            st_d.val  = ((rem3 != '0) || hit_sum[CW]) ? '0 : quot;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign sum_code  = st_q.code;
    assign sum_val   = st_q.val;
    assign err_code  = st_q.bad;
    assign err_ovf   = st_q.ovf;

    // R3: valid strobe follows the accepted input by one cycle
    a_r3_valid_lag: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r3_valid_drop: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R4: code is preserved by addition when nothing is injected
    a_r4_clean_sum: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fault_en) |=> !err_code);

    // R5: any in-range single flip is caught
    a_r5_flip_seen: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && fault_en && (fault_pos <= PW'(CW))) |=> err_code);

    // R8: decoder output matches coded sum when unflagged, zero otherwise
    a_r8_decode_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !err_code && !err_ovf) |->
        (({2'b00, sum_val} * (DW+3)'(3)) == {1'b0, sum_code}));
    a_r8_flag_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (err_code || err_ovf) |-> (sum_val == '0));

    // R9: results hold while no operands arrive
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(sum_code) && $stable(sum_val)
                       && $stable(err_code) && $stable(err_ovf)));
endmodule

// File: tb/tb_an_add_check.sv
module tb_an_add_check;
    localparam int DW = 16;
    localparam int CW = DW + 2;
    localparam int PW = $clog2(CW + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [DW-1:0] a_val = '0;
    logic [DW-1:0] b_val = '0;
    logic          fault_en = 1'b0;
    logic [PW-1:0] fault_pos = '0;
    logic          out_valid;
    logic [CW-1:0] sum_code;
    logic [DW:0]   sum_val;
    logic          err_code;
    logic          err_ovf;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    longint e_code = 0;
    longint e_val  = 0;
    bit     e_vld  = 0;
    bit     e_bad  = 0;
    bit     e_ovf  = 0;
    string  t_code = "R1";
    string  t_err  = "R1";
    string  t_ovf  = "R1";
    string  t_val  = "R1";
    string  t_vld  = "R1";

    always #2 clk = ~clk;

    an_add_check #(.DW(DW)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .a_val(a_val), .b_val(b_val), .fault_en(fault_en),
        .fault_pos(fault_pos), .out_valid(out_valid),
        .sum_code(sum_code), .sum_val(sum_val),
        .err_code(err_code), .err_ovf(err_ovf)
    );

    task automatic cmp(string tag, string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare_all();
        cmp(t_vld,  "out_valid", longint'(out_valid), longint'(e_vld));
        cmp(t_code, "sum_code",  longint'(sum_code),  e_code);
        cmp(t_err,  "err_code",  longint'(err_code),  longint'(e_bad));
        cmp(t_ovf,  "err_ovf",   longint'(err_ovf),   longint'(e_ovf));
        cmp(t_val,  "sum_val",   longint'(sum_val),   e_val);
    endtask

    // apply one cycle: check the previous result, drive, predict
    task automatic step(bit v, int a, int b, bit fe, int fp);
        longint raw;
        compare_all();
        in_valid  = v;
        a_val     = DW'(a);
        b_val     = DW'(b);
        fault_en  = fe;
        fault_pos = PW'(fp);
        e_vld = v;
        t_vld = "R3";
        if (v) begin
            raw = 3 * longint'(a) + 3 * longint'(b);
            if (fe && fp <= CW) raw = raw ^ (longint'(1) << fp);
            e_code = raw % (longint'(1) << CW);
            e_ovf  = ((raw >> CW) & 1) != 0;
            e_bad  = (raw % 3) != 0;
            e_val  = (e_bad || e_ovf) ? 0 : e_code / 3;
            t_code = (fe && fp > CW) ? "R6" : "R2";
            t_err  = (fe && fp <= CW) ? "R5" : (fe ? "R6" : "R4");
            t_ovf  = (fe && fp > CW) ? "R6" : "R7";
            t_val  = (fe && fp > CW) ? "R6" : "R8";
        end else begin
            t_code = "R9"; t_err = "R9"; t_ovf = "R9"; t_val = "R9";
        end
        @(negedge clk);
    endtask

    initial begin
        int mx;
        mx = (1 << DW) - 1;
        @(negedge clk);
        @(negedge clk);
        compare_all();                 // R1 during reset
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after release, R2/R3/R4/R8 basic sums
        step(1, 0, 0, 0, 0);
        step(1, 1, 2, 0, 0);
        step(1, mx, 0, 0, 0);
        step(1, 12345, 5432, 0, 0);
        step(1, 29127, 58254, 0, 0);   // just below carry threshold
        step(1, 29128, 58254, 0, 0);   // R7 carry, no fault
        step(1, mx, mx, 0, 0);         // R7 largest operands
        // R9 hold with busy inputs, fault request ignored
        step(0, 777, 888, 1, 3);
        step(0, 1, 1, 0, 0);
        step(1, 100, 200, 0, 0);
        // R5 every position of the raw sum, carry included
        for (int p = 0; p <= CW; p++) step(1, 4321, 1234, 1, p);
        // R6 positions beyond the carry
        for (int p = CW + 1; p < (1 << PW); p++) step(1, 999, 1, 1, p);
        // R5 with R7: fault on an overflowing sum
        step(1, mx, mx, 1, 0);
        step(1, mx, mx, 1, CW);
        step(1, 0, 0, 1, CW);
        // random mix
        for (int k = 0; k < 400; k++) begin
            int ra, rb, rp;
            bit rv, rf;
            ra = int'($urandom_range(mx, 0));
            rb = int'($urandom_range(mx, 0));
            rp = int'($urandom_range((1 << PW) - 1, 0));
            rv = ($urandom_range(3, 0) != 0);
            rf = ($urandom_range(2, 0) == 0);
            step(rv, ra, rb, rf, rp);
        end
        step(0, 0, 0, 0, 0);
        compare_all();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule